// File: doc/BRIEF.md
# Pin Event Interrupt Detector

This block watches three groups of eight general-purpose input pins and turns selected pin activity into interrupt requests. Each pin is configured on its own: it can catch a transition or follow a level, with either polarity. Each pin can also be routed through a noise filter and gated by an enable bit. Transitions are held in a per-pin latch until software clears them by writing ones. Level conditions are never latched and follow the pin.

Software configures the block over a byte-wide register bus with a single-cycle write strobe and a combinational read. It sees a masked pending byte per group. The first two groups (index 0 and 1) are merged into one shared interrupt line. Each pin of the third group (index 2) has its own interrupt line. Raw pins enter through a two-flop synchronizer. When the filter is enabled, a change is accepted only once it has persisted for a set number of sample ticks.

Top module: `pirq_top`

## Requirements
- R1: After reset, every register reads 0x00 and all interrupt outputs are low.
- R2: The bus address is {group[1:0], reg[2:0]}. reg 0 is edge-select (1 = edge, 0 = level), reg 1 is polarity (1 = rising/high, 0 = falling/low), reg 3 is enable and reg 5 is filter-enable. Each of these reads back the last byte written to it. Group 3 and reg codes 6 and 7 ignore writes and read 0x00.
- R3: A pin in edge mode with polarity 1 latches an event on a 0-to-1 transition. The event stays pending after the pin returns low.
- R4: A pin in edge mode with polarity 0 latches only on a 1-to-0 transition. A rising transition leaves it clear.
- R5: A pin in level mode is pending exactly while its synchronized value equals its polarity bit. Nothing is latched.
- R6: Writing reg 2 clears the edge latch of every pin whose data bit is 1. Bits written as 0 leave their latches unchanged, and reg 2 reads 0x00. A clear wins over an event in the same cycle.
- R7: A write to reg 0 or reg 1 of a group clears all edge latches of that group.
- R8: Reg 4 (read-only) returns the enable byte ANDed with the pending state. An edge latched while its enable bit is 0 stays hidden and appears once the bit is set.
- R9: `irqAB` is high exactly when any status bit of group 0 or group 1 is set.
- R10: `irqF[i]` equals status bit i of group 2.
- R11: With a pin's filter bit set, a change that lasts fewer than DB_TICKS sample ticks (one tick every TICK_DIV clocks) is ignored. A change held longer is accepted. With the bit clear, a pulse of three clocks is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| busAddr | input | 5 | Register address {group, reg} |
| busWr | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr |
| pinsA | input | 8 | Raw pins of group 0 |
| pinsB | input | 8 | Raw pins of group 1 |
| pinsF | input | 8 | Raw pins of group 2 |
| irqAB | output | 1 | Shared interrupt for groups 0 and 1 |
| irqF | output | 8 | Per-pin interrupts of group 2 |

## Verification
A wrong latch bit shows as a status byte that no longer matches the enable mask and the edge history. It also shows on `irqAB` or `irqF` within about three clocks of the pin change, because of the synchronizer and edge register. A stuck filter counter shows as a filtered pin that never settles, or settles too early, after a few tens of clocks. A missed clear or an extra clear is visible on the next status read after the bus write. Random level sweeps with random polarity cover the live path against a bench model. Directed sequences cover latching, masking, clearing and filtering.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int PIN_W  = 8;
  localparam int PORT_N = 3;
  localparam int ADDR_W = 5;

  localparam logic [2:0] REG_EDGE   = 3'd0;
  localparam logic [2:0] REG_POL    = 3'd1;
  localparam logic [2:0] REG_CLR    = 3'd2;
  localparam logic [2:0] REG_EN     = 3'd3;
  localparam logic [2:0] REG_STATUS = 3'd4;
  localparam logic [2:0] REG_FILT   = 3'd5;

  typedef struct packed {
    logic [PORT_N-1:0] edgeWr;
    logic [PORT_N-1:0] polWr;
    logic [PORT_N-1:0] clrWr;
    logic [PORT_N-1:0] enWr;
    logic [PORT_N-1:0] filtWr;
    logic [1:0]        rdPort;
    logic [2:0]        rdReg;
  } pirq_strobe_t;
endpackage

// File: rtl/pirq_ctrl.sv
module pirq_ctrl
  import pirq_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  output pirq_strobe_t      strobes
);
  logic [1:0] portSel;
  logic [2:0] regSel;

  assign portSel = busAddr[4:3];
  assign regSel  = busAddr[2:0];

  always_comb begin
    strobes = '0;
    strobes.rdPort = portSel;
    strobes.rdReg  = regSel;
    for (int p = 0; p < PORT_N; p++) begin
      if (busWr && portSel == 2'(p)) begin
        strobes.edgeWr[p] = (regSel == REG_EDGE);
        strobes.polWr[p]  = (regSel == REG_POL);
        strobes.clrWr[p]  = (regSel == REG_CLR);
        strobes.enWr[p]   = (regSel == REG_EN);
        strobes.filtWr[p] = (regSel == REG_FILT);
      end
    end
  end
endmodule

// File: rtl/pirq_datapath.sv
module pirq_datapath
  import pirq_pkg::*;
#(
  parameter int TICK_DIV = 4,
  parameter int DB_TICKS = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  pirq_strobe_t                  strobes,
  input  logic [PIN_W-1:0]              wdata,
  input  logic [PORT_N-1:0][PIN_W-1:0]  pinsRaw,
  output logic [PIN_W-1:0]              rdata,
  output logic [PORT_N-1:0][PIN_W-1:0]  statusVec
);
  localparam int TDIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int CNT_W  = (DB_TICKS > 1) ? $clog2(DB_TICKS) : 1;

  logic [PORT_N-1:0][PIN_W-1:0] edgeVec, polVec, enVec, filtEnVec;
  logic [PORT_N-1:0][PIN_W-1:0] syncA, syncB, filtVec, effVec, prevVec, latchVec;
  logic [TDIV_W-1:0] divCnt;
  logic              tick;

  assign tick = (divCnt == TDIV_W'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (tick) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  for (genvar p = 0; p < PORT_N; p++) begin : g_port
    logic [PIN_W-1:0] hit;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        edgeVec[p]   <= '0;
        polVec[p]    <= '0;
        enVec[p]     <= '0;
        filtEnVec[p] <= '0;
        syncA[p]     <= '0;
        syncB[p]     <= '0;
        prevVec[p]   <= '0;
        latchVec[p]  <= '0;
      end else begin
        if (strobes.edgeWr[p]) edgeVec[p]   <= wdata;
        if (strobes.polWr[p])  polVec[p]    <= wdata;
        if (strobes.enWr[p])   enVec[p]     <= wdata;
        if (strobes.filtWr[p]) filtEnVec[p] <= wdata;
        syncA[p]   <= pinsRaw[p];
        syncB[p]   <= syncA[p];
        prevVec[p] <= effVec[p];
        if (strobes.edgeWr[p] || strobes.polWr[p]) latchVec[p] <= '0;
        else if (strobes.clrWr[p]) latchVec[p] <= (latchVec[p] | hit) & ~wdata;
        else latchVec[p] <= latchVec[p] | hit;
      end
    end

    for (genvar i = 0; i < PIN_W; i++) begin : g_pin
      logic [CNT_W-1:0] stableCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          filtVec[p][i] <= 1'b0;
          stableCnt     <= '0;
        end else if (tick) begin
          if (syncB[p][i] == filtVec[p][i]) stableCnt <= '0;
          else if (stableCnt == CNT_W'(DB_TICKS - 1)) begin
            filtVec[p][i] <= syncB[p][i];
            stableCnt     <= '0;
          end else stableCnt <= stableCnt + 1'b1;
        end
      end
      assign effVec[p][i] = filtEnVec[p][i] ? filtVec[p][i] : syncB[p][i];
    end

    assign hit = edgeVec[p] & ((polVec[p] & effVec[p] & ~prevVec[p]) |
                               (~polVec[p] & ~effVec[p] & prevVec[p]));
    assign statusVec[p] = enVec[p] &
        ((edgeVec[p] & latchVec[p]) |
         (~edgeVec[p] & ~(polVec[p] ^ effVec[p])));
  end

  always_comb begin
    rdata = '0;
    if (strobes.rdPort < 2'(PORT_N)) begin
      case (strobes.rdReg)
        REG_EDGE:   rdata = edgeVec[strobes.rdPort];
        REG_POL:    rdata = polVec[strobes.rdPort];
        REG_EN:     rdata = enVec[strobes.rdPort];
        REG_STATUS: rdata = statusVec[strobes.rdPort];
        REG_FILT:   rdata = filtEnVec[strobes.rdPort];
        default:    rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pirq_top.sv
module pirq_top
  import pirq_pkg::*;
#(
  parameter int TICK_DIV = 4,
  parameter int DB_TICKS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [4:0]  busAddr,
  input  logic        busWr,
  input  logic [7:0]  busWdata,
  output logic [7:0]  busRdata,
  input  logic [7:0]  pinsA,
  input  logic [7:0]  pinsB,
  input  logic [7:0]  pinsF,
  output logic        irqAB,
  output logic [7:0]  irqF
);
  pirq_strobe_t                 strobes;
  logic [PORT_N-1:0][PIN_W-1:0] statusVec;
  logic [PORT_N-1:0][PIN_W-1:0] pinsRaw;

  assign pinsRaw = {pinsF, pinsB, pinsA};

  pirq_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWr   (busWr),
    .strobes (strobes)
  );

  pirq_datapath #(.TICK_DIV(TICK_DIV), .DB_TICKS(DB_TICKS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wdata     (busWdata),
    .pinsRaw   (pinsRaw),
    .rdata     (busRdata),
    .statusVec (statusVec)
  );

  assign irqAB = |(statusVec[0] | statusVec[1]);
  assign irqF  = statusVec[2];
endmodule

// File: rtl/pirq_checker.sv
module pirq_checker (
  input logic                 clk,
  input logic                 rstN,
  input logic [4:0]           busAddr,
  input logic                 busWr,
  input logic [7:0]           busWdata,
  input logic                 irqAB,
  input logic [7:0]           irqF,
  input logic [2:0][7:0]      statusVec,
  input logic [2:0][7:0]      latchVec,
  input logic [2:0][7:0]      enVec
);
  // R2: enable register of group 0 takes the written byte
  a_r2_enable_write: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 5'h03) |=> (enVec[0] == $past(busWdata)));

  // R6: an all-ones clear empties the group 2 latches, whatever arrives with it
  a_r6_clear_all: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 5'h12 && busWdata == 8'hFF) |=> (latchVec[2] == 8'h00));

  // R7: a type write to group 0 empties its latches
  a_r7_type_clears: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && (busAddr == 5'h00 || busAddr == 5'h01)) |=> (latchVec[0] == 8'h00));

  // R8: no status bit without its enable bit
  a_r8_masked: assert property (@(posedge clk) disable iff (!rstN)
    ((statusVec[1] & ~enVec[1]) == 8'h00));

  // R9: shared line follows groups 0 and 1
  a_r9_shared_line: assert property (@(posedge clk) disable iff (!rstN)
    irqAB == ((statusVec[0] != 8'h00) || (statusVec[1] != 8'h00)));

  // R10: group 2 lines mirror its status
  a_r10_per_pin: assert property (@(posedge clk) disable iff (!rstN)
    irqF == statusVec[2]);
endmodule

bind pirq_top pirq_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWr     (busWr),
  .busWdata  (busWdata),
  .irqAB     (irqAB),
  .irqF      (irqF),
  .statusVec (statusVec),
  .latchVec  (u_dp.latchVec),
  .enVec     (u_dp.enVec)
);

// File: tb/pirq_top_tb.sv
module pirq_top_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] busAddr = '0;
  logic       busWr = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [7:0] pinsA = '0, pinsB = '0, pinsF = '0;
  logic       irqAB;
  logic [7:0] irqF;

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pirq_top u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .pinsA(pinsA),
    .pinsB(pinsB), .pinsF(pinsF), .irqAB(irqAB), .irqF(irqF)
  );

  function automatic logic [7:0] levelStatus(logic [7:0] en, logic [7:0] pol,
                                             logic [7:0] pins);
    return en & ~(pol ^ pins);
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    logic [7:0] model [3][8];
    void'($urandom(32'd7001));
    for (int p = 0; p < 3; p++) for (int r = 0; r < 8; r++) model[p][r] = 8'h00;
    waitClk(3);
    rstN = 1'b1;
    waitClk(2);

    // R1: reset state
    for (int a = 0; a < 24; a++) begin
      rd(5'(a), v);
      check("R1 reset read", v, 8'h00);
    end
    check("R1 irqAB", {7'd0, irqAB}, 8'h00);
    check("R1 irqF", irqF, 8'h00);

    // R3: rising edge latch on group 0 pin 0
    wr(5'h00, 8'hFF); wr(5'h01, 8'hFF); wr(5'h03, 8'h01);
    pinsA = 8'h01; waitClk(5);
    rd(5'h04, v); check("R3 rise latched", v, 8'h01);
    check("R9 irqAB on group0", {7'd0, irqAB}, 8'h01);
    pinsA = 8'h00; waitClk(5);
    rd(5'h04, v); check("R3 held after pin low", v, 8'h01);

    // R6: zero bits do nothing, one bits clear
    wr(5'h02, 8'h00);
    rd(5'h04, v); check("R6 zero write keeps", v, 8'h01);
    rd(5'h02, v); check("R6 clear reg reads zero", v, 8'h00);
    wr(5'h02, 8'h01);
    rd(5'h04, v); check("R6 one clears", v, 8'h00);
    check("R9 irqAB low after clear", {7'd0, irqAB}, 8'h00);

    // R4: falling edge on group 1
    wr(5'h08, 8'hFF); wr(5'h09, 8'h00); wr(5'h0B, 8'hFF);
    pinsB = 8'hFF; waitClk(5);
    rd(5'h0C, v); check("R4 rise ignored", v, 8'h00);
    pinsB = 8'hF7; waitClk(5);
    rd(5'h0C, v); check("R4 fall latched", v, 8'h08);
    check("R9 irqAB from group1", {7'd0, irqAB}, 8'h01);

    // R7: rewriting polarity clears the group latches
    wr(5'h09, 8'h00);
    rd(5'h0C, v); check("R7 type write clears", v, 8'h00);

    // R8: masked edge stays hidden, then appears
    wr(5'h0B, 8'hDF);
    pinsB = 8'hD7; waitClk(5);
    rd(5'h0C, v); check("R8 masked hidden", v, 8'h00);
    check("R8 irqAB masked", {7'd0, irqAB}, 8'h00);
    wr(5'h0B, 8'hFF);
    rd(5'h0C, v); check("R8 unmask shows latch", v, 8'h20);
    wr(5'h0A, 8'hFF);
    // R2: unused group 3 and reg 6 ignore writes
    wr(5'h1B, 8'hAA); wr(5'h06, 8'h55);
    rd(5'h1B, v); check("R2 group3 ignored", v, 8'h00);
    rd(5'h06, v); check("R2 reg6 ignored", v, 8'h00);

    // R11: filter on pin 0, none on pin 1, group 2
    wr(5'h10, 8'h03); wr(5'h11, 8'h03); wr(5'h15, 8'h01); wr(5'h13, 8'h03);
    @(negedge clk); pinsF = 8'h03;
    waitClk(3); pinsF = 8'h00;
    waitClk(40);
    rd(5'h14, v); check("R11 short pulse filtered vs raw", v, 8'h02);
    check("R10 irqF mirrors", irqF, 8'h02);
    wr(5'h12, 8'h02);
    @(negedge clk); pinsF = 8'h01;
    waitClk(8); pinsF = 8'h00;
    waitClk(40);
    rd(5'h14, v); check("R11 8-clock glitch filtered", v, 8'h00);
    pinsF = 8'h01; waitClk(60);
    rd(5'h14, v); check("R11 held change accepted", v, 8'h01);
    check("R10 irqF bit0", irqF, 8'h01);
    pinsF = 8'h00;
    wr(5'h12, 8'hFF);
    rd(5'h14, v); check("R6 clear group2", v, 8'h00);

    // R2: random readback of configuration registers
    for (int k = 0; k < 40; k++) begin
      int p; int r; logic [7:0] d; logic [2:0] codes [4];
      codes = '{3'd0, 3'd1, 3'd3, 3'd5};
      p = $urandom_range(0, 2);
      r = codes[$urandom_range(0, 3)];
      d = 8'($urandom);
      wr({2'(p), 3'(r)}, d);
      model[p][r] = d;
      rd({2'(p), 3'(r)}, v);
      check("R2 readback", v, model[p][r]);
    end

    // R5/R10: random level sweeps on group 2
    wr(5'h10, 8'h00); wr(5'h15, 8'h00);
    for (int k = 0; k < 30; k++) begin
      logic [7:0] pol; logic [7:0] en; logic [7:0] pins;
      pol = 8'($urandom); en = 8'($urandom); pins = 8'($urandom);
      wr(5'h11, pol); wr(5'h13, en);
      pinsF = pins; waitClk(4);
      rd(5'h14, v); check("R5 level status", v, levelStatus(en, pol, pins));
      check("R10 irqF level", irqF, levelStatus(en, pol, pins));
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule